// File: doc/BRIEF.md
# Upper-Area Memory Chip-Select Decoder

This block sits on the 20-bit memory bus of an 8088-class processor board. It turns the address, the active-low memory read and write strobes, and a small set of configuration switches into two active-low chip selects. One select is for the on-board SRAM and one is for the 128 KiB flash ROM. It also drives the flash's remapped A16 line and a flag that marks a memory cycle left to the expansion bus. The low 640 KiB always goes to SRAM. The 128 KiB display area always goes to the expansion bus. The top 64 KiB always goes to the flash.

The 192 KiB from 0xC0000 up is split into six 32 KiB windows. Window `i` starts at `0xC0000 + i*0x8000`. A switch bit per window either gives that window to SRAM as an upper memory block or leaves it free for option ROMs on the expansion bus. A separate switch lets the flash also answer in the E segment (0xE0000–0xEFFFF), and there it takes precedence over windows 4 and 5. The flash A16 line is the inverse of CPU A16. As a result, the lower half of the ROM image is seen in segment F and the upper half in segment E, and the reset fetch at 0xFFFF0 reads ROM offset 0x0FFF0.

The switches are captured into a configuration register only on clock edges where the active-low address latch strobe is low. A switch that moves during a bus cycle therefore cannot disturb a select already driven. The parameter `REG_OUT` can add a clocked output stage. With the default of 0 the decode is combinational from the address and strobes.

Top module: `xt_mem_decode`

## Requirements
- R1: With a read or write strobe active, every address from 0x00000 to 0x9FFFF asserts `sramCsN` (low), leaves `flashCsN` high and drives `offBoard` low.
- R2: With a strobe active, addresses 0xA0000 to 0xBFFFF assert neither select and drive `offBoard` high.
- R3: With a strobe active, an address in window `i` (0xC0000 + i*0x8000, i = 0..5) asserts `sramCsN` when `umbSw[i]` is 1 in the captured configuration. Otherwise it asserts no select and drives `offBoard` high. This holds unless R5 applies.
- R4: With a strobe active, addresses 0xF0000 to 0xFFFFF assert `flashCsN` and never `sramCsN`, for every configuration.
- R5: When the captured `eFlashSw` is 1, addresses 0xE0000 to 0xEFFFF assert `flashCsN` and not `sramCsN`, whatever `umbSw[5:4]` hold. When it is 0, the E segment follows R3.
- R6: `flashA16` equals the inverse of `addr[16]` for every address. Address 0xFFFF0 gives `flashA16` = 0 (ROM offset 0x0FFF0), and 0xEFFF0 gives `flashA16` = 1.
- R7: At most one select is low at any time. When both `memRdN` and `memWrN` are high, both selects are high and `offBoard` is low.
- R8: A write strobe to a flash-decoded address asserts `flashCsN` and leaves `sramCsN` high.
- R9: `umbSw` and `eFlashSw` are captured at rising clock edges where `latchN` is 0. Changes made while `latchN` is 1 have no effect on the selects until the next such edge.
- R10: Reset (`rstN` low) clears the captured configuration to all windows off and E-segment flash off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register and the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| latchN | input | 1 | Active-low address latch strobe; switches are captured while low |
| addr | input | 20 | CPU memory address |
| memRdN | input | 1 | Active-low memory read strobe |
| memWrN | input | 1 | Active-low memory write strobe |
| umbSw | input | 6 | Per-window switch, bit i = 1 gives window i to SRAM |
| eFlashSw | input | 1 | 1 = flash also answers in segment E |
| sramCsN | output | 1 | Active-low on-board SRAM select |
| flashCsN | output | 1 | Active-low flash ROM select |
| flashA16 | output | 1 | A16 line to the flash, inverse of CPU A16 |
| offBoard | output | 1 | High when a strobed cycle selects no on-board device |

## Verification
The decode is swept over all 128 switch settings. In each setting, the first and last byte of every 32 KiB window is driven, alternating read and write strobes. The two ends catch an off-by-one window edge, and the strobe mix separates the write-path rule for flash from plain reads. Directed patterns drive the reset fetch address, idle strobes, and the state just after reset. A switch change made while the latch strobe is high is checked to make sure it is not taken early, which separates a register that samples only on the strobe from one that follows the switches continuously.

// File: rtl/xt_dec_pkg.sv
package xt_dec_pkg;

  localparam int UMB_WINDOWS = 6;

  typedef struct packed {
    logic [UMB_WINDOWS-1:0] umbSram;
    logic                   eFlash;
  } cfg_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic any;
  } strobe_t;

  typedef enum logic [1:0] {
    RG_BASE    = 2'd0,
    RG_DISPLAY = 2'd1,
    RG_UMB     = 2'd2,
    RG_SYSROM  = 2'd3
  } region_t;

endpackage

// File: rtl/xt_dec_ctrl.sv
module xt_dec_ctrl
  import xt_dec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   latchN,
  input  logic                   memRdN,
  input  logic                   memWrN,
  input  logic [UMB_WINDOWS-1:0] umbSw,
  input  logic                   eFlashSw,
  output cfg_t                   cfgQ,
  output strobe_t                str
);

  logic loadCfg;
  cfg_t cfgNext;

  assign loadCfg         = ~latchN;
  assign cfgNext.umbSram = umbSw;
  assign cfgNext.eFlash  = eFlashSw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (loadCfg) begin
      cfgQ <= cfgNext;
    end
  end

  always_comb begin
    str.rd  = ~memRdN;
    str.wr  = ~memWrN;
    str.any = str.rd | str.wr;
  end

  // R9: configuration only moves on a latch-low edge
  a_r9_hold_while_latched: assert property (@(posedge clk) disable iff (!rstN)
    (latchN && rstN) |=> $stable(cfgQ));

  a_r9_capture_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    (!latchN && rstN) |=> (cfgQ == {$past(umbSw), $past(eFlashSw)}));

endmodule

// File: rtl/xt_dec_path.sv
module xt_dec_path
  import xt_dec_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int WIN_BITS     = 15,
  parameter int SEG_BITS     = 16,
  parameter int BASE_WINS    = 20,
  parameter int UMB_FIRST    = 24,
  parameter int ROM_FLIP_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_t              cfg,
  input  strobe_t           str,
  output logic              sramCsN,
  output logic              flashCsN,
  output logic              flashA16,
  output logic              offBoard
);

  localparam int WIN_IDX_W  = ADDR_W - WIN_BITS;
  localparam int SEG_WINS   = 1 << (SEG_BITS - WIN_BITS);
  localparam int ROM_FIRST  = UMB_FIRST + UMB_WINDOWS;
  localparam int ESEG_FIRST = ROM_FIRST - SEG_WINS;
  localparam int SEG_W      = ADDR_W - SEG_BITS;

  logic [WIN_IDX_W-1:0]   winIdx;
  logic [UMB_WINDOWS-1:0] umbHit;
  logic [UMB_WINDOWS-1:0] eOverride;
  region_t                region;
  logic                   eSegHit;
  logic                   sramHit;
  logic                   flashHit;

  assign winIdx = addr[ADDR_W-1:WIN_BITS];

  always_comb begin
    if (winIdx < WIN_IDX_W'(BASE_WINS))       region = RG_BASE;
    else if (winIdx < WIN_IDX_W'(UMB_FIRST))  region = RG_DISPLAY;
    else if (winIdx < WIN_IDX_W'(ROM_FIRST))  region = RG_UMB;
    else                                      region = RG_SYSROM;
  end

  assign eSegHit = (winIdx >= WIN_IDX_W'(ESEG_FIRST)) && (winIdx < WIN_IDX_W'(ROM_FIRST));

  genvar gi;
  generate
    for (gi = 0; gi < UMB_WINDOWS; gi++) begin : g_win
      assign umbHit[gi] = (winIdx == WIN_IDX_W'(UMB_FIRST + gi));
      if (UMB_FIRST + gi >= ESEG_FIRST) begin : g_eseg
        assign eOverride[gi] = cfg.eFlash;
      end else begin : g_plain
        assign eOverride[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    sramHit  = 1'b0;
    flashHit = 1'b0;
    unique case (region)
      RG_BASE:    sramHit  = 1'b1;
      RG_DISPLAY: sramHit  = 1'b0;
      RG_UMB: begin
        sramHit  = |(umbHit & cfg.umbSram & ~eOverride);
        flashHit = cfg.eFlash & eSegHit;
      end
      RG_SYSROM:  flashHit = 1'b1;
      default:    sramHit  = 1'b0;
    endcase
  end

  assign sramCsN  = ~(sramHit & str.any);
  assign flashCsN = ~(flashHit & str.any);
  assign offBoard = str.any & ~sramHit & ~flashHit;
  assign flashA16 = ~addr[ROM_FLIP_BIT];

  // R7: on-board selects are mutually exclusive
  a_r7_single_select: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramCsN && !flashCsN));

  // R4: system ROM segment always reaches the flash
  a_r4_sysrom_flash: assert property (@(posedge clk) disable iff (!rstN)
    (str.any && (addr[ADDR_W-1 -: SEG_W] == '1)) |-> (!flashCsN && sramCsN));

  // R2: display area goes to the expansion bus
  a_r2_display_offboard: assert property (@(posedge clk) disable iff (!rstN)
    (str.any && (addr[ADDR_W-1 -: 3] == 3'b101)) |-> (offBoard && sramCsN && flashCsN));

  // R5: enabled E-segment flash wins over SRAM windows
  a_r5_eseg_flash: assert property (@(posedge clk) disable iff (!rstN)
    (str.any && cfg.eFlash && (addr[ADDR_W-1 -: SEG_W] == 4'hE)) |-> (!flashCsN && sramCsN));

  // R6: reset fetch lands in the lower ROM half
  a_r6_reset_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(20'hFFFF0)) |-> !flashA16);

endmodule

// File: rtl/xt_mem_decode.sv
module xt_mem_decode
  import xt_dec_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   latchN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   memRdN,
  input  logic                   memWrN,
  input  logic [UMB_WINDOWS-1:0] umbSw,
  input  logic                   eFlashSw,
  output logic                   sramCsN,
  output logic                   flashCsN,
  output logic                   flashA16,
  output logic                   offBoard
);

  cfg_t    cfgQ;
  strobe_t str;
  logic    sramCsNComb;
  logic    flashCsNComb;
  logic    flashA16Comb;
  logic    offBoardComb;

  xt_dec_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .latchN  (latchN),
    .memRdN  (memRdN),
    .memWrN  (memWrN),
    .umbSw   (umbSw),
    .eFlashSw(eFlashSw),
    .cfgQ    (cfgQ),
    .str     (str)
  );

  xt_dec_path #(.ADDR_W(ADDR_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .cfg     (cfgQ),
    .str     (str),
    .sramCsN (sramCsNComb),
    .flashCsN(flashCsNComb),
    .flashA16(flashA16Comb),
    .offBoard(offBoardComb)
  );

  generate
    if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sramCsN  <= 1'b1;
          flashCsN <= 1'b1;
          flashA16 <= 1'b1;
          offBoard <= 1'b0;
        end else begin
          sramCsN  <= sramCsNComb;
          flashCsN <= flashCsNComb;
          flashA16 <= flashA16Comb;
          offBoard <= offBoardComb;
        end
      end
    end else begin : g_comb_out
      assign sramCsN  = sramCsNComb;
      assign flashCsN = flashCsNComb;
      assign flashA16 = flashA16Comb;
      assign offBoard = offBoardComb;

      // R7: idle strobes leave every select released
      a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
        (memRdN && memWrN) |-> (sramCsN && flashCsN && !offBoard));
    end
  endgenerate

endmodule

// File: tb/xt_mem_decode_tb_top.sv
module xt_mem_decode_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        latchN;
  logic [19:0] addr;
  logic        memRdN;
  logic        memWrN;
  logic [5:0]  umbSw;
  logic        eFlashSw;
  logic        sramCsN;
  logic        flashCsN;
  logic        flashA16;
  logic        offBoard;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  logic [5:0] shUmb;
  logic       shE;

  always #(CLK_PERIOD/2) clk = ~clk;

  xt_mem_decode dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .latchN  (latchN),
    .addr    (addr),
    .memRdN  (memRdN),
    .memWrN  (memWrN),
    .umbSw   (umbSw),
    .eFlashSw(eFlashSw),
    .sramCsN (sramCsN),
    .flashCsN(flashCsN),
    .flashA16(flashA16),
    .offBoard(offBoard)
  );

  // expected {sramCsN, flashCsN, flashA16, offBoard}
  function automatic logic [3:0] refDecode(input logic [19:0] a, input bit rd, input bit wr,
                                           input logic [5:0] umb, input logic eEn);
    int  w;
    bit  act, sr, fl;
    w   = int'(a >> 15);
    act = rd || wr;
    sr  = 1'b0;
    fl  = 1'b0;
    if (w < 20) sr = 1'b1;
    else if (w >= 24 && w < 30) begin
      if (eEn && w >= 28) fl = 1'b1;
      else sr = umb[w-24];
    end else if (w >= 30) fl = 1'b1;
    return {~(sr && act), ~(fl && act), ~a[16], act && !sr && !fl};
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [19:0] a, input bit rd, input bit wr);
    logic [3:0] exp;
    logic [3:0] got;
    @(negedge clk);
    addr   = a;
    memRdN = !rd;
    memWrN = !wr;
    #1;
    exp = refDecode(a, rd, wr, shUmb, shE);
    got = {sramCsN, flashCsN, flashA16, offBoard};
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s addr=%05h rd=%0d wr=%0d got=%04b expected=%04b (sramCsN,flashCsN,flashA16,offBoard)",
               tag, a, rd, wr, got, exp);
    end
  endtask

  task automatic setCfg(input logic [5:0] u, input logic e);
    @(negedge clk);
    umbSw    = u;
    eFlashSw = e;
    latchN   = 1'b0;
    @(negedge clk);
    latchN   = 1'b1;
    shUmb    = u;
    shE      = e;
  endtask

  function automatic string tagFor(input int w);
    if (w < 20) return "R1";
    if (w < 24) return "R2";
    if (w >= 30) return "R4";
    if (w >= 28) return "R5";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN     = 1'b0;
    latchN   = 1'b1;
    addr     = '0;
    memRdN   = 1'b1;
    memWrN   = 1'b1;
    umbSw    = 6'h3F;
    eFlashSw = 1'b1;
    shUmb    = '0;
    shE      = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R10: cleared config, switches not yet captured
    check("R10", 20'hC0000, 1, 0);
    check("R10", 20'hE0000, 1, 0);
    check("R10", 20'hE8000, 0, 1);

    // R1, R2 directed edges
    check("R1", 20'h00000, 1, 0);
    check("R1", 20'h9FFFF, 0, 1);
    check("R2", 20'hA0000, 1, 0);
    check("R2", 20'hBFFFF, 0, 1);

    // R7: idle strobes
    check("R7", 20'h00000, 0, 0);
    check("R7", 20'hFFFF0, 0, 0);

    // R6: reset fetch and E segment view
    setCfg(6'h00, 1'b1);
    check("R6", 20'hFFFF0, 1, 0);
    check("R6", 20'hEFFF0, 1, 0);
    check("R6", 20'h10000, 1, 0);

    // R8: writes to flash-decoded addresses
    setCfg(6'h3F, 1'b1);
    check("R8", 20'hF8000, 0, 1);
    check("R8", 20'hE0000, 0, 1);
    check("R8", 20'hE8000, 0, 1);

    // R9: switch changes while latch high are ignored
    setCfg(6'h3F, 1'b0);
    @(negedge clk);
    umbSw    = 6'h00;
    eFlashSw = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", 20'hC0000, 1, 0);
    check("R9", 20'hE0000, 1, 0);
    check("R9", 20'hE8000, 0, 1);
    @(negedge clk);
    latchN = 1'b0;
    @(negedge clk);
    latchN = 1'b1;
    shUmb  = 6'h00;
    shE    = 1'b1;
    check("R9", 20'hC0000, 1, 0);
    check("R9", 20'hE0000, 1, 0);

    // R3/R4/R5 sweep: every configuration, both ends of each window
    for (int c = 0; c < 128; c++) begin
      setCfg(6'(c), c[6]);
      for (int w = 0; w < 32; w++) begin
        check(tagFor(w), 20'(w << 15), 1, 0);
        check(tagFor(w), 20'((w << 15) | 32'h7FFF), 0, 1);
      end
      check("R7", 20'hC8000, 0, 0);
    end

    finishRun();
  end

endmodule